// File: doc/BRIEF.md
# Processor exception entry controller

This block computes the privileged control state a pipelined core with branch delay slots needs when a synchronous exception is taken. One request carries a 5-bit exception code, the faulting instruction's PC and the PC that would have followed it. It also carries the current Status, Cause and shadow-set control words and a vector base address. From these the block produces the updated Status, Cause, EPC and shadow-set control words, and the handler PC, next PC and next-next PC that the fetch stage loads.

The request side is a valid/ready handshake. Every result is written in the same register stage, so the block accepts one request per cycle and never applies back-pressure. `req_ready` is low during reset and high from the first clock edge after reset releases. A transfer happens on any rising edge with both `req_valid` and `req_ready` high. The results are presented on the following cycle together with a one-cycle `done_o` pulse. They then hold their values until the next accepted request. The result side is plain and has no ready, so the consumer must capture the results while `done_o` is high.

The core is said to be in a delay slot when PC + 4 differs from the next PC. The shadow-set control word packs three 4-bit fields: current set in bits 3:0, previous set in bits 9:6, and the set assigned to exceptions in bits 15:12. Status.EXL is bit 1 and Status.BEV is bit 22.

Top module: `exc_entry_ctrl`

## Requirements
- R1: During reset and in the first sampled cycle after reset, `done_o` is 0, `req_ready` is 0 during reset, and all result outputs are 0. From the first edge after reset onward, `req_ready` is 1.
- R2: An accepted request is a delay slot exactly when `npc_i != pc_i + 4`. In that case Cause bit 31 is set to 1; otherwise Cause bit 31 is cleared to 0.
- R3: EPC is `pc_i - 4` (modulo 2^32) for a delay slot and `pc_i` otherwise.
- R4: Cause bits 6:2 take `req_code` and Cause bits 29:28 are cleared. All other Cause bits are copied from `cause_i`.
- R5: Status bit 1 (EXL) is set to 1 whether or not it was already set. All other Status bits are copied from `status_i`.
- R6: When Status bits 1 and 22 of `status_i` are both 0, the new shadow-set word has bits 9:6 equal to the old bits 3:0 and bits 3:0 equal to the old bits 15:12. All other bits are copied.
- R7: When Status bit 1 or bit 22 of `status_i` is 1, the shadow-set word is passed through unchanged.
- R8: The handler PC is `vec_base_i + 0x180` for codes 1, 2 and 3 (the TLB class). It is `vec_base_i + 0x200` for every other code, including integer overflow (code 0xC).
- R9: The handler next PC is the handler PC + 4, and the handler next-next PC is the handler PC + 8.
- R10: `done_o` is high in the cycle after each accepted request and low otherwise. Results appear in that same cycle.
- R11: When no request is accepted, every result output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request valid |
| req_ready | output | 1 | Request ready, high from the first edge after reset |
| req_code | input | 5 | Exception code |
| pc_i | input | 32 | PC of the faulting instruction |
| npc_i | input | 32 | PC that would have followed it |
| status_i | input | 32 | Current Status word |
| cause_i | input | 32 | Current Cause word |
| srsctl_i | input | 32 | Current shadow-set control word |
| vec_base_i | input | 32 | Exception vector base address |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| status_o | output | 32 | New Status word |
| cause_o | output | 32 | New Cause word |
| epc_o | output | 32 | New EPC |
| srsctl_o | output | 32 | New shadow-set control word |
| hnd_pc_o | output | 32 | Handler PC |
| hnd_npc_o | output | 32 | Handler next PC |
| hnd_nnpc_o | output | 32 | Handler next-next PC |

## Verification
The bench sweeps every exception code against both delay-slot cases and all four EXL/BEV combinations, and adds a faulting PC of zero inside a delay slot. A design that mishandled the gating would rotate the shadow fields when EXL or BEV was set, or would leave them unchanged when both were clear. A wrong operator order in the EPC selection would show up as an EPC of 0 or 4 instead of PC or PC - 4. The zero-PC case checks that the EPC wraps to 0xFFFFFFFC. The code sweep reaches both edges of the TLB-class range (codes 0, 1, 3 and 4), where an off-by-one would pick the wrong vector offset. Idle gaps between requests catch a `done_o` that stays high and result outputs that drift while no request is accepted.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned CODE_W     = 5;
  localparam int unsigned SS_W       = 4;
  localparam int unsigned INSN_BYTES = 4;

  localparam int unsigned EXL_BIT    = 1;
  localparam int unsigned BEV_BIT    = 22;

  localparam int unsigned BD_BIT     = 31;
  localparam int unsigned CE_LSB     = 28;
  localparam int unsigned CE_W       = 2;
  localparam int unsigned CODE_LSB   = 2;

  localparam int unsigned CSS_LSB    = 0;
  localparam int unsigned PSS_LSB    = 6;
  localparam int unsigned ESS_LSB    = 12;

  localparam logic [XLEN-1:0] TLB_OFF = 32'h0000_0180;
  localparam logic [XLEN-1:0] GEN_OFF = 32'h0000_0200;
  localparam int unsigned TLB_CODE_LO = 1;
  localparam int unsigned TLB_CODE_HI = 3;

  typedef struct packed {
    logic [XLEN-1:0] status;
    logic [XLEN-1:0] cause;
    logic [XLEN-1:0] epc;
    logic [XLEN-1:0] srsctl;
    logic [XLEN-1:0] hpc;
    logic [XLEN-1:0] hnpc;
    logic [XLEN-1:0] hnnpc;
  } entry_state_t;
endpackage

// File: rtl/exc_slot_detect.sv
module exc_slot_detect #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  output logic            in_slot_o,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] branch_pc;

  always_comb begin
    seq_pc    = pc_i + STEP;
    branch_pc = pc_i - STEP;
    in_slot_o = (seq_pc != npc_i);
    epc_o     = in_slot_o ? branch_pc : pc_i;
  end
endmodule

// File: rtl/exc_shadow_rotate.sv
module exc_shadow_rotate #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned SS_W    = 4,
  parameter int unsigned CSS_LSB = 0,
  parameter int unsigned PSS_LSB = 6,
  parameter int unsigned ESS_LSB = 12
) (
  input  logic [XLEN-1:0] srs_i,
  input  logic            rotate_i,
  output logic [XLEN-1:0] srs_o
);
  logic [XLEN-1:0] rotated;

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b >= PSS_LSB && b < PSS_LSB + SS_W) begin : g_pss
      assign rotated[b] = srs_i[CSS_LSB + (b - PSS_LSB)];
    end else if (b >= CSS_LSB && b < CSS_LSB + SS_W) begin : g_css
      assign rotated[b] = srs_i[ESS_LSB + (b - CSS_LSB)];
    end else begin : g_keep
      assign rotated[b] = srs_i[b];
    end
  end

  assign srs_o = rotate_i ? rotated : srs_i;
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     CODE_W      = 5,
  parameter int unsigned     INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] TLB_OFF     = 32'h180,
  parameter logic [XLEN-1:0] GEN_OFF     = 32'h200,
  parameter int unsigned     TLB_CODE_LO = 1,
  parameter int unsigned     TLB_CODE_HI = 3
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   npc_o,
  output logic [XLEN-1:0]   nnpc_o
);
  localparam logic [XLEN-1:0]   STEP = XLEN'(INSN_BYTES);
  localparam logic [CODE_W-1:0] LO   = CODE_W'(TLB_CODE_LO);
  localparam logic [CODE_W-1:0] HI   = CODE_W'(TLB_CODE_HI);

  logic tlb_class;

  always_comb begin
    tlb_class = (code_i >= LO) && (code_i <= HI);
    pc_o      = base_i + (tlb_class ? TLB_OFF : GEN_OFF);
    npc_o     = pc_o + STEP;
    nnpc_o    = npc_o + STEP;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned W  = XLEN,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_code,
  input  logic [W-1:0]  pc_i,
  input  logic [W-1:0]  npc_i,
  input  logic [W-1:0]  status_i,
  input  logic [W-1:0]  cause_i,
  input  logic [W-1:0]  srsctl_i,
  input  logic [W-1:0]  vec_base_i,
  output logic          done_o,
  output logic [W-1:0]  status_o,
  output logic [W-1:0]  cause_o,
  output logic [W-1:0]  epc_o,
  output logic [W-1:0]  srsctl_o,
  output logic [W-1:0]  hnd_pc_o,
  output logic [W-1:0]  hnd_npc_o,
  output logic [W-1:0]  hnd_nnpc_o
);
  localparam logic [W-1:0] CE_MASK   = W'(((1 << CE_W) - 1) << CE_LSB);
  localparam logic [W-1:0] CODE_MASK = W'(((1 << CW) - 1) << CODE_LSB);
  localparam logic [W-1:0] BD_MASK   = W'(1) << BD_BIT;

  logic         in_slot;
  logic [W-1:0] epc_n;
  logic [W-1:0] srs_n;
  logic [W-1:0] hpc_n, hnpc_n, hnnpc_n;
  logic         rotate;
  logic         accept;
  entry_state_t nxt, cur;
  logic         ready_q, done_q;

  assign accept = req_valid && ready_q;
  assign rotate = !status_i[EXL_BIT] && !status_i[BEV_BIT];

  exc_slot_detect #(.XLEN(W), .INSN_BYTES(INSN_BYTES)) slot_i (
    .pc_i      (pc_i),
    .npc_i     (npc_i),
    .in_slot_o (in_slot),
    .epc_o     (epc_n)
  );

  exc_shadow_rotate #(
    .XLEN(W), .SS_W(SS_W),
    .CSS_LSB(CSS_LSB), .PSS_LSB(PSS_LSB), .ESS_LSB(ESS_LSB)
  ) shadow_i (
    .srs_i    (srsctl_i),
    .rotate_i (rotate),
    .srs_o    (srs_n)
  );

  exc_vector_gen #(
    .XLEN(W), .CODE_W(CW), .INSN_BYTES(INSN_BYTES),
    .TLB_OFF(TLB_OFF), .GEN_OFF(GEN_OFF),
    .TLB_CODE_LO(TLB_CODE_LO), .TLB_CODE_HI(TLB_CODE_HI)
  ) vec_i (
    .base_i (vec_base_i),
    .code_i (req_code),
    .pc_o   (hpc_n),
    .npc_o  (hnpc_n),
    .nnpc_o (hnnpc_n)
  );

  always_comb begin
    nxt.status = status_i | (W'(1) << EXL_BIT);
    nxt.cause  = (cause_i & ~(CE_MASK | CODE_MASK | BD_MASK))
               | (W'(req_code) << CODE_LSB)
               | (in_slot ? BD_MASK : '0);
    nxt.epc    = epc_n;
    nxt.srsctl = srs_n;
    nxt.hpc    = hpc_n;
    nxt.hnpc   = hnpc_n;
    nxt.hnnpc  = hnnpc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      cur     <= '0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= accept;
      if (accept) cur <= nxt;
    end
  end

  assign req_ready  = ready_q;
  assign done_o     = done_q;
  assign status_o   = cur.status;
  assign cause_o    = cur.cause;
  assign epc_o      = cur.epc;
  assign srsctl_o   = cur.srsctl;
  assign hnd_pc_o   = cur.hpc;
  assign hnd_npc_o  = cur.hnpc;
  assign hnd_nnpc_o = cur.hnnpc;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int unsigned W          = 32,
  parameter int unsigned EXL_BIT    = 1,
  parameter int unsigned BEV_BIT    = 22,
  parameter int unsigned INSN_BYTES = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [W-1:0] pc_i,
  input logic [W-1:0] npc_i,
  input logic [W-1:0] status_i,
  input logic [W-1:0] srsctl_i,
  input logic         done_o,
  input logic [W-1:0] status_o,
  input logic [W-1:0] cause_o,
  input logic [W-1:0] epc_o,
  input logic [W-1:0] srsctl_o,
  input logic [W-1:0] hnd_pc_o,
  input logic [W-1:0] hnd_npc_o,
  input logic [W-1:0] hnd_nnpc_o
);
  localparam logic [W-1:0] STEP = W'(INSN_BYTES);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> done_o);
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !done_o);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(epc_o) && $stable(cause_o) && $stable(hnd_pc_o)));
  a_r5_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> status_o[EXL_BIT]);
  a_r4_ce_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cause_o[29:28] == 2'b00));
  a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hnd_npc_o == hnd_pc_o + STEP && hnd_nnpc_o == hnd_npc_o + STEP));
  a_r3_epc: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (epc_o == ((cause_o[31]) ? $past(pc_i) - STEP : $past(pc_i))));
  a_r2_bd: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cause_o[31] == ($past(npc_i) != $past(pc_i) + STEP)));
  a_r7_srs_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (status_i[EXL_BIT] || status_i[BEV_BIT])) |=> (srsctl_o == $past(srsctl_i)));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .W(W), .EXL_BIT(exc_entry_pkg::EXL_BIT), .BEV_BIT(exc_entry_pkg::BEV_BIT),
  .INSN_BYTES(exc_entry_pkg::INSN_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .pc_i(pc_i), .npc_i(npc_i), .status_i(status_i), .srsctl_i(srsctl_i),
  .done_o(done_o), .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o),
  .srsctl_o(srsctl_o), .hnd_pc_o(hnd_pc_o), .hnd_npc_o(hnd_npc_o),
  .hnd_nnpc_o(hnd_nnpc_o)
);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_code = '0;
  logic [31:0] pc_i = '0, npc_i = '0, status_i = '0, cause_i = '0;
  logic [31:0] srsctl_i = '0, vec_base_i = '0;
  logic        done_o;
  logic [31:0] status_o, cause_o, epc_o, srsctl_o;
  logic [31:0] hnd_pc_o, hnd_npc_o, hnd_nnpc_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .pc_i(pc_i), .npc_i(npc_i), .status_i(status_i),
    .cause_i(cause_i), .srsctl_i(srsctl_i), .vec_base_i(vec_base_i),
    .done_o(done_o), .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o),
    .srsctl_o(srsctl_o), .hnd_pc_o(hnd_pc_o), .hnd_npc_o(hnd_npc_o),
    .hnd_nnpc_o(hnd_nnpc_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  logic [31:0] e_status, e_cause, e_epc, e_srs, e_hpc;

  task automatic apply(input int code, input bit slot, input bit exl, input bit bev,
                       input logic [31:0] pc);
    logic [31:0] st;
    logic [31:0] srs;
    logic [31:0] cs;
    st  = 32'h1234_5670 ^ 32'(code << 8);
    st[1]  = exl;
    st[22] = bev;
    srs = 32'h0000_0000 | 32'((code ^ 5) & 15) << 12 | 32'((code * 3) & 15)
        | 32'h00A0_0000 | 32'((code + 2) & 15) << 6;
    cs  = 32'h7FFF_FF83 ^ 32'(code << 16);
    @(negedge clk);
    req_valid  = 1'b1;
    req_code   = 5'(code);
    pc_i       = pc;
    npc_i      = slot ? pc + 32'd20 : pc + 32'd4;
    status_i   = st;
    cause_i    = cs;
    srsctl_i   = srs;
    vec_base_i = 32'h8000_0000 + 32'(code << 12);
    // expected values
    e_status = st | 32'h2;
    e_cause  = (cs & ~32'hB000_007C) | (32'(code) << 2) | (slot ? 32'h8000_0000 : 32'h0);
    e_epc    = slot ? pc - 32'd4 : pc;
    e_srs    = srs;
    if (!exl && !bev) begin
      e_srs[9:6] = srs[3:0];
      e_srs[3:0] = srs[15:12];
    end
    e_hpc = vec_base_i + ((code >= 1 && code <= 3) ? 32'h180 : 32'h200);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 done", 32'(done_o), 32'd1);
    chk("R5 status", status_o, e_status);
    chk("R2/R4 cause", cause_o, e_cause);
    chk("R2 bd", 32'(cause_o[31]), 32'(slot));
    chk("R3 epc", epc_o, e_epc);
    chk((!exl && !bev) ? "R6 srs rotate" : "R7 srs keep", srsctl_o, e_srs);
    chk("R8 hpc", hnd_pc_o, e_hpc);
    chk("R9 hnpc", hnd_npc_o, e_hpc + 32'd4);
    chk("R9 hnnpc", hnd_nnpc_o, e_hpc + 32'd8);
  endtask

  task automatic idle_check;
    @(negedge clk);
    chk("R10 done low", 32'(done_o), 32'd0);
    chk("R11 hold epc", epc_o, e_epc);
    chk("R11 hold cause", cause_o, e_cause);
    chk("R11 hold srs", srsctl_o, e_srs);
    chk("R11 hold hpc", hnd_pc_o, e_hpc);
  endtask

  initial begin
    #1;
    chk("R1 ready in reset", 32'(req_ready), 32'd0);
    chk("R1 done in reset", 32'(done_o), 32'd0);
    chk("R1 epc in reset", epc_o, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 hpc", hnd_pc_o, 32'd0);
    chk("R1 status", status_o, 32'd0);
    for (int code = 0; code < 32; code++) begin
      for (int mode = 0; mode < 8; mode++) begin
        apply(code, mode[0], mode[1], mode[2], 32'h0040_1000 + 32'(code * 64 + mode * 8));
        if (mode == 7) idle_check();
      end
    end
    apply(12, 1'b1, 1'b0, 1'b0, 32'h0000_0000);
    chk("R3 wrap", epc_o, 32'hFFFF_FFFC);
    apply(12, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFC);
    chk("R2 seq wrap bd", 32'(cause_o[31]), 32'd0);
    idle_check();
    idle_check();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule